// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character into a serial frame on a single output line. Each accepted write sends one frame. A frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. Bit timing comes from a one-cycle baud tick that an outside rate generator supplies. Each tick starts the next bit.

Transmission runs only when both the power enable and the transmit enable are high. These two enables pass through an internal synchronizer chain. A write is accepted one base clock after the enables rise. Lowering either enable for two consecutive clock edges puts the serializer back to idle, so it can be enabled again right away. The frame shape (parity mode, character length and stop count) is captured while the transmit enable is low and is held while it is high.

Top module: `uart_tx_core`

## Requirements
- R1: After a synchronous reset, `txd` is 1 and `busy` and `tx_done` are 0.
- R2: A frame is sent one bit per baud tick. The tick after the write drives the start bit (0). Each following tick drives the next bit: the data LSB first, then the parity bit if any, then the stop bits (1). `txd` is 1 whenever `busy` is 0.
- R3: `par_sel` encodes 2'b00 = no parity bit, 2'b01 = parity bit always 0, 2'b10 = odd parity (the data bits plus the parity bit hold an odd count of ones), 2'b11 = even parity (an even count).
- R4: `len8` = 1 sends 8 data bits and `len8` = 0 sends 7. With 7 bits, bit 7 of `wr_data` is neither sent nor counted in the parity.
- R5: `stop2` = 0 sends one stop bit and `stop2` = 1 sends two.
- R6: `busy` goes high on the clock edge that accepts a write. It stays high until the tick that ends the last stop bit. On that edge `busy` falls and `tx_done` is 1 for exactly one cycle.
- R7: A write is accepted only if `pwr_en` and `tx_en` are both 1 and `busy` is 0 at that edge. Any other write is ignored: no frame is sent and the frame in progress is unchanged.
- R8: A write made one base clock after `tx_en` rises (with `pwr_en` already high) is accepted and sent in full.
- R9: `par_sel`, `len8` and `stop2` are captured on every edge where `tx_en` is 0. Changes made while `tx_en` is 1 do not affect any frame sent until `tx_en` next goes low.
- R10: If `pwr_en` and `tx_en` are not both 1 on two consecutive edges, then after the second edge `busy` is 0, `txd` is 1, and no `tx_done` pulse appears for the dropped frame. A write after re-enabling sends a complete new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse that starts each bit period |
| pwr_en | input | 1 | Power enable for the transmitter |
| tx_en | input | 1 | Transmit enable |
| par_sel | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| len8 | input | 1 | Character length: 1 = 8 bits, 0 = 7 bits |
| stop2 | input | 1 | Stop bits: 1 = two, 0 = one |
| wr_stb | input | 1 | Write strobe for the transmit data |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | A frame is pending or being sent |
| tx_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The main sweep sends every combination of the four parity modes, the two lengths and the two stop counts. Each combination is sent with all-zero, all-one, alternating and single-set-bit characters. The all-zero and all-one characters show whether odd and even parity are mixed up and whether the forced-zero mode is kept apart from them. Characters with bit 7 set show whether that bit leaks into 7-bit frames or into their parity. Further cases cover writes while disabled, writes while busy, configuration changes while enabled, a write one clock after enabling, and an abort in the middle of a frame followed by an immediate restart.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    par_mode_e par;
    logic      len8;
    logic      stop2;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{par: PAR_NONE, len8: 1'b1, stop2: 1'b0};

endpackage

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_first,
  output logic [WIDTH-1:0] q_last
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_first = chain[0];
  assign q_last  = chain[STAGES-1];

endmodule

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      open_win,
  input  logic [1:0] par_in,
  input  logic      len8_in,
  input  logic      stop2_in,
  output tx_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (open_win) begin
      cfg.par   <= par_mode_e'(par_in);
      cfg.len8  <= len8_in;
      cfg.stop2 <= stop2_in;
    end
  end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  tx_cfg_t             cfg,
  input  logic [DATA_W-1:0]   data,
  output logic [FRAME_W-1:0]  bits,
  output logic [CNT_W-1:0]    nbits
);

  logic [DATA_W-1:0] used;
  logic              par_bit;
  logic              has_par;
  int                nd;

  always_comb begin
    nd   = cfg.len8 ? DATA_W : DATA_W - 1;
    used = data;
    if (!cfg.len8) used[DATA_W-1] = 1'b0;
    has_par = (cfg.par != PAR_NONE);
    unique case (cfg.par)
      PAR_ODD:  par_bit = ~(^used);
      PAR_EVEN: par_bit = ^used;
      default:  par_bit = 1'b0;
    endcase

    bits    = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) bits[i+1] = used[i];
    end
    if (has_par) bits[nd+1] = par_bit;

    nbits = CNT_W'(1 + nd + (has_par ? 1 : 0) + (cfg.stop2 ? 2 : 1));
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               advance_ok,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [CNT_W-1:0]   frame_len,
  output logic               txd,
  output logic               busy,
  output logic               done
);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh_q   <= frame_bits;
        left_q <= frame_len;
        busy   <= 1'b1;
      end else if (busy && advance_ok && baud_tick) begin
        if (left_q != '0) begin
          txd    <= sh_q[0];
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
          txd  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              pwr_en,
  input  logic              tx_en,
  input  logic [1:0]        par_sel,
  input  logic              len8,
  input  logic              stop2,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              busy,
  output logic              tx_done
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [1:0]         en_first;
  logic [1:0]         en_last;
  logic               run_raw;
  logic               run_first;
  logic               run_sync;
  logic               clear;
  logic               load;
  tx_cfg_t            cfg_q;
  logic [FRAME_W-1:0] frame_bits;
  logic [CNT_W-1:0]   frame_len;

  uart_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d       ({pwr_en, tx_en}),
    .q_first (en_first),
    .q_last  (en_last)
  );

  assign run_raw   = pwr_en & tx_en;
  assign run_first = en_first[1] & en_first[0];
  assign run_sync  = en_last[1] & en_last[0];
  assign clear     = ~run_raw & ~run_first;
  assign load      = wr_stb & run_raw & ~busy;

  uart_tx_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .open_win (~tx_en),
    .par_in   (par_sel),
    .len8_in  (len8),
    .stop2_in (stop2),
    .cfg      (cfg_q)
  );

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .cfg   (cfg_q),
    .data  (wr_data),
    .bits  (frame_bits),
    .nbits (frame_len)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .advance_ok (run_sync),
    .baud_tick  (baud_tick),
    .load       (load),
    .frame_bits (frame_bits),
    .frame_len  (frame_len),
    .txd        (txd),
    .busy       (busy),
    .done       (tx_done)
  );

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk
  import uart_tx_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    pwr_en,
  input logic    tx_en,
  input logic    wr_stb,
  input logic    txd,
  input logic    busy,
  input logic    tx_done,
  input tx_cfg_t cfg_q
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!busy && $past(busy)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  assert_start_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_stb && pwr_en && tx_en));

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (rst)
    $past(tx_en) |-> $stable(cfg_q));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!(pwr_en && tx_en) && $past(!(pwr_en && tx_en))) |=> (!busy && !tx_done));

endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwr_en  (pwr_en),
  .tx_en   (tx_en),
  .wr_stb  (wr_stb),
  .txd     (txd),
  .busy    (busy),
  .tx_done (tx_done),
  .cfg_q   (cfg_q)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       pwr_en = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic       len8 = 1'b1;
  logic       stop2 = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd;
  logic       busy;
  logic       tx_done;

  int n_checks = 0;
  int n_fails  = 0;
  int tick_cnt = 0;

  uart_tx_core u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .pwr_en(pwr_en), .tx_en(tx_en),
    .par_sel(par_sel), .len8(len8), .stop2(stop2), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .busy(busy), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt == DIV-1) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == DIV-1);
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
  endtask

  // reconfigure with the enable low, then enable; leaves caller at a negedge
  task automatic setup(input logic [1:0] p, input logic l8, input logic s2);
    @(negedge clk);
    tx_en = 1'b0;
    par_sel = p; len8 = l8; stop2 = s2;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
  endtask

  // write at the current negedge and check the whole frame against cfg (p,l8,s2)
  task automatic send(input logic [7:0] d, input logic [1:0] p, input logic l8,
                      input logic s2, input string tag);
    int nd, ones, n;
    logic [11:0] exp_bits;
    nd = l8 ? 8 : 7;
    ones = 0;
    exp_bits = '1;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      exp_bits[i+1] = d[i];
      ones += d[i];
    end
    n = 1 + nd;
    if (p != 2'b00) begin
      exp_bits[n] = (p == 2'b01) ? 1'b0 : (p == 2'b10) ? ((ones % 2) == 0) : ((ones % 2) == 1);
      n++;
    end
    n += s2 ? 2 : 1;
    wr_stb = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
    check({tag, " R6 busy after write"}, busy, 1);
    for (int b = 0; b < n; b++) begin
      wait_tick();
      @(negedge clk);
      check($sformatf("%s R2/R3/R4/R5 bit %0d", tag, b), txd, exp_bits[b]);
      check({tag, " R6 busy mid"}, busy, 1);
      check({tag, " R6 no early done"}, tx_done, 0);
    end
    wait_tick();
    @(negedge clk);
    check({tag, " R6 done pulse"}, tx_done, 1);
    check({tag, " R6 busy low"}, busy, 0);
    check({tag, " R2 idle high"}, txd, 1);
    @(negedge clk);
    check({tag, " R6 done single"}, tx_done, 0);
  endtask

  logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h80, 8'h01};

  initial begin
    repeat (3) @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 busy", busy, 0);
    check("R1 done", tx_done, 0);
    rst = 1'b0;
    pwr_en = 1'b1;
    @(negedge clk);

    // R3 R4 R5 sweep; each write is one clock after enable (R8)
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 2; l++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 6; k++) begin
            setup(2'(p), 1'(l), 1'(s));
            send(pats[k], 2'(p), 1'(l), 1'(s), "R8 sweep");
          end

    // R7: write while disabled is ignored
    @(negedge clk);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_stb = 1'b0;
    for (int i = 0; i < 4*DIV; i++) begin
      check("R7 disabled write busy", busy, 0);
      check("R7 disabled write txd", txd, 1);
      @(negedge clk);
    end

    // R9: config changes while enabled are ignored
    setup(2'b00, 1'b1, 1'b0);
    par_sel = 2'b10; len8 = 1'b0; stop2 = 1'b1;
    send(8'h81, 2'b00, 1'b1, 1'b0, "R9 held");
    send(8'h7E, 2'b00, 1'b1, 1'b0, "R9 held again");

    // R7: write while busy is ignored
    setup(2'b11, 1'b1, 1'b0);
    fork
      send(8'hC3, 2'b11, 1'b1, 1'b0, "R7 busy write");
      begin
        repeat (3*DIV) @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_stb = 1'b0;
      end
    join
    for (int i = 0; i < 4*DIV; i++) begin
      check("R7 no second frame", busy, 0);
      @(negedge clk);
    end

    // R10: abort mid-frame, then immediate restart
    setup(2'b10, 1'b1, 1'b1);
    wr_stb = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (3*DIV) @(negedge clk);
    check("R10 mid-frame busy", busy, 1);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 abort busy", busy, 0);
    check("R10 abort txd", txd, 1);
    check("R10 abort no done", tx_done, 0);
    tx_en = 1'b1;
    @(negedge clk);
    send(8'h5A, 2'b10, 1'b1, 1'b1, "R10 restart");

    // R10: power drop behaves the same
    wr_stb = 1'b1; wr_data = 8'hF0;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (2*DIV) @(negedge clk);
    pwr_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 power abort busy", busy, 0);
    check("R10 power abort txd", txd, 1);
    pwr_en = 1'b1;
    @(negedge clk);
    send(8'h0F, 2'b10, 1'b1, 1'b1, "R10 power restart");

    report();
  end

endmodule